// File: doc/BRIEF.md
# Single-Cycle Eight-Instruction 32-bit Processor Core

This block is a 32-bit processor that completes one instruction per clock: fetch, decode, operand read, arithmetic, memory access and write-back all settle within the cycle and commit on the rising edge. It executes a fixed subset of eight MIPS-style instructions: load upper immediate, add immediate unsigned, add, subtract unsigned, load word, store word, branch on equal and jump. It holds its own program counter, a 32-entry register file, an ALU, branch and jump target logic and a main decoder. It also holds two small word arrays for code and data.

The core is brought up by holding reset while the code and data arrays are filled through a load port. Reset is then released and the program runs. Architectural state is observed through two combinational observation ports, one for registers and one for data words, and through the program counter output. Code occupies byte addresses from 0x00400000 upward, so absolute jump targets land inside the code array.

Top module: `mips8_core`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the PC loads 0x00400000 and all registers clear to zero. The first instruction after release is code word 0, and the PC then reads 0x00400004 and 0x00400008 on the two following cycles.
- R2: LUI (opcode 0x0F, immediate in bits 15:0, destination rt in bits 20:16) writes the immediate into the upper half of rt and zeroes the lower half.
- R3: ADDIU (opcode 0x09) writes rs plus the sign-extended immediate into rt, so an immediate of 0xFFFF adds -1.
- R4: R-type instructions (opcode 0x00, rs in bits 25:21, rt in 20:16, rd in 15:11, function in 5:0) with function 0x20 write rs+rt and with function 0x23 write rs-rt into rd. Both wrap modulo 2^32, and signed overflow raises no trap.
- R5: Register 0 always reads zero, and an instruction that names it as destination leaves it zero.
- R6: LW (opcode 0x23) reads the data word at index (rs + sign-extended offset) / 4 into rt. Negative offsets are allowed.
- R7: SW (opcode 0x2B) writes rt into the data word at index (rs + sign-extended offset) / 4.
- R8: BEQ (opcode 0x04) sets the PC to PC+4 plus the sign-extended offset times four when rs equals rt, and to PC+4 otherwise. A negative offset of -1 holds the PC on the branch itself.
- R9: J (opcode 0x02) sets the PC to the upper four bits of PC+4 joined with the 26-bit target field shifted left by two.
- R10: An opcode outside the subset, or an R-type function other than 0x20 and 0x23, writes no register and no data word and advances the PC by 4. Every instruction other than BEQ and J also advances the PC by 4.
- R11: When an instruction reads and writes the same register, its operands use the value from before that cycle's write. For example, an LW whose base is also its destination addresses memory with the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Write one word into the code or data array |
| load_to_data | input | 1 | 0 selects the code array, 1 selects the data array |
| load_addr | input | MEM_AW | Word index for the load write |
| load_data | input | 32 | Word to load |
| obs_reg_addr | input | 5 | Register to observe |
| obs_reg_data | output | 32 | Current value of the observed register |
| obs_mem_addr | input | MEM_AW | Data word index to observe |
| obs_mem_data | output | 32 | Current value of the observed data word |
| pc | output | 32 | Program counter of the instruction executing this cycle |

## Verification
The functions that share a cycle here are the register-file read and the register-file write of one instruction. In the same edge, a data-memory address is also formed from a register that is being overwritten. This is provoked with a load word whose base register is also its destination, with a store to a word that is read back later, and with an immediate load aimed at register 0. The result is judged by the loaded value: it must come from the address built from the old base, and register 0 must still read zero. Branch taken and not taken, a jump over code, a self-looping branch and undefined encodings that would write a register or memory if decoded wrongly are judged from final register, memory and PC contents.

// File: rtl/mips8_pkg.sv
package mips8_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREGS  = 1 << REG_AW;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDIU = 6'h09;
    localparam logic [5:0] OP_LUI   = 6'h0F;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUBU = 6'h23;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_HI16 = 2'd2,
        ALU_NONE = 2'd3
    } alu_op_e;

    // Field view of an instruction word
    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } instr_t;

    // Control bundle produced by the decoder
    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    src_imm;
        logic    mem_load;
        logic    mem_store;
        logic    branch_eq;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        reg_we:    1'b0,
        dst_is_rd: 1'b0,
        src_imm:   1'b0,
        mem_load:  1'b0,
        mem_store: 1'b0,
        branch_eq: 1'b0,
        jump:      1'b0,
        alu_op:    ALU_NONE
    };

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic word_t imm_of(input instr_t i);
        return sext16({i.rd, i.shamt, i.funct});
    endfunction

    function automatic word_t jump_dest(input logic [3:0] region, input instr_t i);
        return {region, i.rs, i.rt, i.rd, i.shamt, i.funct, 2'b00};
    endfunction

    function automatic word_t branch_dest(input word_t pc_next, input word_t off);
        return pc_next + {off[XLEN-3:0], 2'b00};
    endfunction

endpackage

// File: rtl/mips8_decoder.sv
module mips8_decoder
    import mips8_pkg::*;
(
    input  instr_t instr,
    output ctrl_t  ctrl
);

    logic unused_dec_fields;
    assign unused_dec_fields = ^{instr.rs, instr.rt, instr.rd, instr.shamt};

    always_comb begin
        ctrl = CTRL_NOP;
        case (instr.op)
            OP_LUI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_HI16;
            end
            OP_ADDIU: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OP_LW: begin
                ctrl.reg_we   = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.mem_load = 1'b1;
                ctrl.alu_op   = ALU_ADD;
            end
            OP_SW: begin
                ctrl.src_imm   = 1'b1;
                ctrl.mem_store = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            OP_BEQ: begin
                ctrl.branch_eq = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OP_J: begin
                ctrl.jump = 1'b1;
            end
            OP_RTYPE: begin
                if (instr.funct == FN_ADD) begin
                    ctrl.reg_we    = 1'b1;
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.alu_op    = ALU_ADD;
                end else if (instr.funct == FN_SUBU) begin
                    ctrl.reg_we    = 1'b1;
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.alu_op    = ALU_SUB;
                end
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/mips8_alu.sv
module mips8_alu
    import mips8_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_op_e op,
    output word_t   y,
    output logic    zero
);

    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_HI16: y = {b[15:0], 16'h0000};
            default:  y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mips8_regfile.sv
module mips8_regfile
    import mips8_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  word_t             wdata,
    input  logic [REG_AW-1:0] raddr [NRD],
    output word_t             rdata [NRD]
);

    word_t regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
        end
    endgenerate

endmodule

// File: rtl/mips8_wordmem.sv
module mips8_wordmem
    import mips8_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NRD = 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr [NRD],
    output word_t         rdata [NRD]
);

    localparam int DEPTH = 1 << AW;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rdata[g] = mem[raddr[g]];
        end
    endgenerate

endmodule

// File: rtl/mips8_core.sv
module mips8_core
    import mips8_pkg::*;
#(
    parameter int          MEM_AW   = 6,
    parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_we,
    input  logic              load_to_data,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [31:0]       load_data,
    input  logic [4:0]        obs_reg_addr,
    output logic [31:0]       obs_reg_data,
    input  logic [MEM_AW-1:0] obs_mem_addr,
    output logic [31:0]       obs_mem_data,
    output logic [31:0]       pc
);

    localparam int IDX_LO = 2;
    localparam int IDX_HI = MEM_AW + 1;

    // Fetch
    word_t             pc_q;
    word_t             pc_next;
    word_t             pc_plus4;
    word_t             fetch_off;
    logic [MEM_AW-1:0] im_raddr [1];
    word_t             im_rdata [1];
    instr_t            ins;

    assign fetch_off   = pc_q - RESET_PC;
    assign im_raddr[0] = fetch_off[IDX_HI:IDX_LO];
    assign ins         = im_rdata[0];
    assign pc_plus4    = pc_q + 32'd4;

    mips8_wordmem #(.AW(MEM_AW), .NRD(1)) u_imem (
        .clk   (clk),
        .we    (load_we & ~load_to_data),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (im_raddr),
        .rdata (im_rdata)
    );

    // Decode
    ctrl_t ctrl;

    mips8_decoder u_dec (
        .instr (ins),
        .ctrl  (ctrl)
    );

    // Register file: port 0 = rs, port 1 = rt, port 2 = observation
    logic [REG_AW-1:0] rf_raddr [3];
    word_t             rf_rdata [3];
    logic              rf_we;
    logic [REG_AW-1:0] rf_waddr;
    word_t             rf_wdata;
    word_t             rs_val;
    word_t             rt_val;

    assign rf_raddr[0] = ins.rs;
    assign rf_raddr[1] = ins.rt;
    assign rf_raddr[2] = obs_reg_addr;
    assign rs_val      = rf_rdata[0];
    assign rt_val      = rf_rdata[1];
    assign obs_reg_data = rf_rdata[2];

    assign rf_we    = ctrl.reg_we & ~rst;
    assign rf_waddr = ctrl.dst_is_rd ? ins.rd : ins.rt;

    mips8_regfile #(.NRD(3)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // Execute
    word_t imm_ext;
    word_t alu_b;
    word_t alu_y;
    logic  alu_zero;

    assign imm_ext = imm_of(ins);
    assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

    mips8_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory: port 0 = core load, port 1 = observation
    logic [MEM_AW-1:0] dm_raddr [2];
    word_t             dm_rdata [2];
    logic              dm_we_core;
    logic              dm_we_load;
    logic              dm_we;
    logic [MEM_AW-1:0] dm_waddr;
    word_t             dm_wdata;

    assign dm_raddr[0]  = alu_y[IDX_HI:IDX_LO];
    assign dm_raddr[1]  = obs_mem_addr;
    assign obs_mem_data = dm_rdata[1];

    assign dm_we_core = ctrl.mem_store & ~rst;
    assign dm_we_load = load_we & load_to_data;
    assign dm_we      = dm_we_core | dm_we_load;
    assign dm_waddr   = dm_we_load ? load_addr : alu_y[IDX_HI:IDX_LO];
    assign dm_wdata   = dm_we_load ? load_data : rt_val;

    mips8_wordmem #(.AW(MEM_AW), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    // Write-back
    assign rf_wdata = ctrl.mem_load ? dm_rdata[0] : alu_y;

    // Next PC
    always_comb begin
        if (ctrl.jump) begin
            pc_next = jump_dest(pc_plus4[31:28], ins);
        end else if (ctrl.branch_eq && alu_zero) begin
            pc_next = branch_dest(pc_plus4, imm_ext);
        end else begin
            pc_next = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc = pc_q;

    logic unused_core_bits;
    assign unused_core_bits = ^{fetch_off[31:IDX_HI+1], fetch_off[1:0],
                                alu_y[31:IDX_HI+1], alu_y[1:0],
                                imm_ext[31:30], pc_plus4[27:0]};

endmodule

// File: rtl/mips8_core_chk.sv
module mips8_core_chk
    import mips8_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_we,
    input logic        dm_we,
    input logic [4:0]  obs_reg_addr,
    input logic [31:0] obs_reg_data
);

    logic [5:0]  op;
    logic [5:0]  fn;
    logic [31:0] seq_pc;
    logic [31:0] exp_jump;
    logic [31:0] exp_branch;
    logic        is_jump;
    logic        is_branch;
    logic        is_undef;

    assign op         = instr[31:26];
    assign fn         = instr[5:0];
    assign seq_pc     = pc + 32'd4;
    assign exp_jump   = {seq_pc[31:28], instr[25:0], 2'b00};
    assign exp_branch = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign is_jump    = (op == 6'h02);
    assign is_branch  = (op == 6'h04);
    assign is_undef   = !(op inside {6'h00, 6'h02, 6'h04, 6'h09, 6'h0F, 6'h23, 6'h2B})
                      || ((op == 6'h00) && !(fn inside {6'h20, 6'h23}));

    p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc == RESET_PC);

    p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
        (!is_jump && !is_branch) |=> pc == $past(seq_pc));

    p_undef_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        is_undef |-> (!rf_we && !dm_we));

    p_jump_target_r9: assert property (@(posedge clk) disable iff (rst)
        is_jump |=> pc == $past(exp_jump));

    p_beq_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (is_branch && rs_val == rt_val) |=> pc == $past(exp_branch));

    p_beq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (is_branch && rs_val != rt_val) |=> pc == $past(seq_pc));

    p_zero_read_r5: assert property (@(posedge clk) disable iff (rst)
        (obs_reg_addr == 5'd0) |-> obs_reg_data == 32'd0);

endmodule

bind mips8_core mips8_core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pc           (pc),
    .instr        (im_rdata[0]),
    .rs_val       (rs_val),
    .rt_val       (rt_val),
    .rf_we        (rf_we),
    .dm_we        (dm_we_core),
    .obs_reg_addr (obs_reg_addr),
    .obs_reg_data (obs_reg_data)
);

// File: tb/test_mips8_core.sv
module test_mips8_core;

    localparam int          MEM_AW = 6;
    localparam logic [31:0] BASE   = 32'h0040_0000;
    localparam int          NPROG  = 25;
    localparam int          NEXP   = 22;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_we = 1'b0;
    logic              load_to_data = 1'b0;
    logic [MEM_AW-1:0] load_addr = '0;
    logic [31:0]       load_data = '0;
    logic [4:0]        obs_reg_addr = '0;
    logic [31:0]       obs_reg_data;
    logic [MEM_AW-1:0] obs_mem_addr = '0;
    logic [31:0]       obs_mem_data;
    logic [31:0]       pc;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    mips8_core #(.MEM_AW(MEM_AW), .RESET_PC(BASE)) i_mips8_core (
        .clk          (clk),
        .rst          (rst),
        .load_we      (load_we),
        .load_to_data (load_to_data),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .obs_reg_addr (obs_reg_addr),
        .obs_reg_data (obs_reg_data),
        .obs_mem_addr (obs_mem_addr),
        .obs_mem_data (obs_mem_data),
        .pc           (pc)
    );

    localparam logic [31:0] PROG [NPROG] = '{
        32'h3c010001,  //  0 lui   $1,1            R2
        32'h3c020002,  //  1 lui   $2,2            R2
        32'h24250400,  //  2 addiu $5,$1,1024      R3
        32'h00221820,  //  3 add   $3,$1,$2        R4
        32'h00412023,  //  4 subu  $4,$2,$1        R4
        32'h2406ffff,  //  5 addiu $6,$0,-1        R3
        32'h3c087fff,  //  6 lui   $8,0x7fff
        32'h01084820,  //  7 add   $9,$8,$8 wraps  R4
        32'h3c000005,  //  8 lui   $0,5 ignored    R5
        32'h8c0a0004,  //  9 lw    $10,4($0)       R6
        32'hac050008,  // 10 sw    $5,8($0)        R7
        32'h240b000c,  // 11 addiu $11,$0,12
        32'h8d6cfffc,  // 12 lw    $12,-4($11)     R6
        32'h8d6b0000,  // 13 lw    $11,0($11)      R11
        32'h10220001,  // 14 beq   $1,$2,+1 falls  R8
        32'h240d0007,  // 15 addiu $13,$0,7
        32'h114a0002,  // 16 beq   $10,$10,+2      R8
        32'h240e0001,  // 17 skipped
        32'h240e0002,  // 18 skipped
        32'h08100015,  // 19 j     word 21         R9
        32'h240f0001,  // 20 skipped
        32'hfe10ffff,  // 21 undefined opcode      R10
        32'h00228021,  // 22 undefined function    R10
        32'ha0050000,  // 23 byte store, undefined R10
        32'h1000ffff   // 24 beq   $0,$0,-1 loop   R8
    };

    localparam logic [31:0] DINIT [4] = '{32'h00000001, 32'h0000000f, 32'h00000000, 32'hcafe0003};

    // entry: [47:44] requirement, [43:42] kind (0 reg, 1 mem, 2 pc), [41:32] index, [31:0] value
    function automatic logic [47:0] mk(input int req, input int kind, input int idx, input logic [31:0] v);
        logic [3:0] r4;
        logic [1:0] k2;
        logic [9:0] i10;
        r4  = req[3:0];
        k2  = kind[1:0];
        i10 = idx[9:0];
        return {r4, k2, i10, v};
    endfunction

    localparam logic [47:0] EXP [NEXP] = '{
        mk(5,  0, 0,  32'h00000000),  // R5
        mk(2,  0, 1,  32'h00010000),  // R2
        mk(2,  0, 2,  32'h00020000),  // R2
        mk(4,  0, 3,  32'h00030000),  // R4
        mk(4,  0, 4,  32'h00010000),  // R4
        mk(3,  0, 5,  32'h00010400),  // R3
        mk(3,  0, 6,  32'hffffffff),  // R3
        mk(2,  0, 8,  32'h7fff0000),  // R2
        mk(4,  0, 9,  32'hfffe0000),  // R4
        mk(6,  0, 10, 32'h0000000f),  // R6
        mk(11, 0, 11, 32'hcafe0003),  // R11
        mk(6,  0, 12, 32'h00010400),  // R6
        mk(8,  0, 13, 32'h00000007),  // R8
        mk(8,  0, 14, 32'h00000000),  // R8
        mk(9,  0, 15, 32'h00000000),  // R9
        mk(10, 0, 16, 32'h00000000),  // R10
        mk(10, 1, 0,  32'h00000001),  // R10
        mk(6,  1, 1,  32'h0000000f),  // R6
        mk(7,  1, 2,  32'h00010400),  // R7
        mk(6,  1, 3,  32'hcafe0003),  // R6
        mk(8,  2, 0,  32'h00400060),  // R8
        mk(10, 0, 7,  32'h00000000)   // R10
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [31:0] v);
        obs_reg_addr = idx[4:0];
        #1;
        v = obs_reg_data;
    endtask

    task automatic read_mem(input int idx, output logic [31:0] v);
        obs_mem_addr = idx[MEM_AW-1:0];
        #1;
        v = obs_mem_data;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, actual running expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;

        // Fill the arrays while held in reset
        for (int i = 0; i < NPROG; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_to_data = 1'b0;
            load_addr = i[MEM_AW-1:0]; load_data = PROG[i];
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_to_data = 1'b1;
            load_addr = i[MEM_AW-1:0]; load_data = DINIT[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 pc in reset", pc, BASE);
        read_reg(1, v);
        check("R1 reg1 in reset", v, 32'h0);

        rst = 1'b0;
        @(negedge clk);
        check("R1 pc after first instruction", pc, BASE + 32'd4);
        @(negedge clk);
        check("R1 pc after second instruction", pc, BASE + 32'd8);

        repeat (40) @(negedge clk);

        // Table walk
        for (int e = 0; e < NEXP; e++) begin
            int          req;
            int          kind;
            int          idx;
            logic [31:0] exp;
            req  = int'(EXP[e][47:44]);
            kind = int'(EXP[e][43:42]);
            idx  = int'(EXP[e][41:32]);
            exp  = EXP[e][31:0];
            if (kind == 0) begin
                read_reg(idx, v);
                check($sformatf("R%0d reg %0d", req, idx), v, exp);
            end else if (kind == 1) begin
                read_mem(idx, v);
                check($sformatf("R%0d mem %0d", req, idx), v, exp);
            end else begin
                check($sformatf("R%0d pc", req), pc, exp);
            end
        end

        // R8: self-loop holds the PC
        @(negedge clk);
        check("R8 pc held on self branch", pc, BASE + 32'h60);

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc after mid-run reset", pc, BASE);
        read_reg(11, v);
        check("R1 reg11 cleared by reset", v, 32'h0);
        rst = 1'b0;
        repeat (40) @(negedge clk);

        // R11: rerun gives the same old-base load result
        read_reg(11, v);
        check("R11 reg11 after rerun", v, 32'hcafe0003);
        read_reg(5, v);
        check("R3 reg5 after rerun", v, 32'h00010400);
        read_reg(0, v);
        check("R5 reg0 after rerun", v, 32'h0);

        finish_run();
    end

endmodule